// File: doc/BRIEF.md
# Instrument Status Event Register

This block gathers internal instrument status into two 16-bit words. The condition word is a registered copy of a set of level inputs. The event word is sticky. Some of its bits latch when the matching condition goes from 0 to 1. The rest latch from dedicated one-cycle pulse inputs that have no condition of their own. Several conditions use inverted sense: they read 0 while an activity runs and 1 when it is idle or when an error has cleared. For those bits, a latched event marks the end of the activity.

A writable enable word masks the event word. The OR of all bits that are set in both words drives a single summary output, which feeds bit 1 of an external status byte. A small register port reads the condition word, reads and clears the event word, and writes and reads the enable word. Each read returns its data one cycle after the request.

Top module: `stat_event_reg`

## Requirements
- R1: After a synchronous active-high reset, the condition, event and enable words are all 0 and `summary_o` is 0.
- R2: The condition word holds `cond_in` as sampled at the previous edge, masked to the condition positions 0,1,2,3,4,8,10,11,13. All other bits read as 0. It is read with `reg_sel`=0.
- R3: A condition-backed event bit is set only on the edge at which its input is 1 while the stored condition bit is 0. A condition that stays at 1 does not set the bit again after a clear.
- R4: A `pulse_in` bit at position 5, 6, 7 or 12 sets the matching event bit at the next edge. Pulses at any other position have no effect.
- R5: Bits 9, 14 and 15 read as 0 in the condition, event and enable words.
- R6: A set event bit stays set until the event word is read. A later fall of its condition does not clear it.
- R7: A read with `reg_sel`=1 and `reg_rd`=1 returns the event word as it was before that edge in `reg_rdata` after the edge, and clears the word. A bit being set at the same edge stays set. `reg_rdata` holds its value when `reg_rd` is 0.
- R8: A write with `reg_sel`=2 and `reg_wr`=1 loads `reg_wdata` into the enable word, with bits 9, 14 and 15 forced to 0. A read with `reg_sel`=2 returns the enable word, and a read with `reg_sel`=3 returns 0.
- R9: `summary_o` is 1 exactly when some bit is 1 in both the event and enable words. A masked event bit is still latched and still readable.
- R10: `summary_o` changes in the cycle after the edge that latched an event or wrote the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_in | input | 16 | Level status inputs; only condition positions are used |
| pulse_in | input | 16 | One-cycle event pulses; only positions 5,6,7,12 are used |
| reg_sel | input | 2 | Register select: 0 condition, 1 event, 2 enable, 3 none |
| reg_rd | input | 1 | Read strobe; event read clears the event word |
| reg_wr | input | 1 | Write strobe (enable word only) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| summary_o | output | 1 | OR of enabled, set event bits |

## Verification
The bench sweeps every bit position through condition rises, pulses and enable masks. It then runs a long pseudo-random stream against an arithmetic model. Three corner cases get targeted checks. The first is a condition held high across a clear: a level-triggered design would re-latch it at once. The second is a pulse or rise at the same edge as an event read: a design that lets the clear win would lose that event. The third is a write to the unused positions 9, 14 and 15: a design that failed to mask them would show stray enable bits and could raise the summary with nothing latched. Pulses at condition positions and fallen conditions are also checked to confirm they leave the event word unchanged.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned STAT_W = 16;
  localparam logic [STAT_W-1:0] STAT_COND_MASK  = 16'h2D1F;
  localparam logic [STAT_W-1:0] STAT_PULSE_MASK = 16'h10E0;

  typedef enum logic [1:0] {
    SEL_COND = 2'd0,
    SEL_EVT  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } stat_sel_e;
endpackage

// File: rtl/stat_cond_track.sv
module stat_cond_track #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] COND_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cond_in,
  output logic [W-1:0] cond_q,
  output logic [W-1:0] rise
);
  logic [W-1:0] cond_m;
  assign cond_m = cond_in & COND_MASK;
  assign rise   = cond_m & ~cond_q;

  always_ff @(posedge clk) begin
    if (rst) cond_q <= '0;
    else     cond_q <= cond_m;
  end

  // R2: stored condition never has bits outside the condition positions
  p_cond_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (cond_q & ~COND_MASK) == '0);
  // R3: a rise at this edge means the stored copy shows 1 afterwards
  p_rise_stores_r3: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((cond_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/stat_event_latch.sv
module stat_event_latch #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] VALID_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] kept;
  assign kept = clr ? '0 : evt_q;

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= (kept | set) & VALID_MASK;
  end

  // R5: unused positions stay 0
  p_evt_unused_r5: assert property (@(posedge clk) disable iff (rst)
    (evt_q & ~VALID_MASK) == '0);
  // R7: a set at the clearing edge survives
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((evt_q & $past(set)) == $past(set)));
  // R6: without a clear no latched bit drops
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
endmodule

// File: rtl/stat_reg_port.sv
module stat_reg_port
  import stat_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] VALID_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   sel,
  input  logic         rd,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cond_q,
  input  logic [W-1:0] evt_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] rdata,
  output logic         evt_clr
);
  stat_sel_e sel_e;
  logic [W-1:0] rd_mux;

  assign sel_e   = stat_sel_e'(sel);
  assign evt_clr = rd && (sel_e == SEL_EVT);

  always_comb begin
    unique case (sel_e)
      SEL_COND: rd_mux = cond_q;
      SEL_EVT:  rd_mux = evt_q;
      SEL_EN:   rd_mux = en_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      rdata <= '0;
    end else begin
      if (wr && sel_e == SEL_EN) en_q <= wdata & VALID_MASK;
      if (rd) rdata <= rd_mux;
    end
  end

  // R8: enable word never holds unused bits
  p_en_unused_r8: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~VALID_MASK) == '0);
  // R7: read data holds between reads
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!rd) |=> $stable(rdata));
  // R8: enable word only moves on an enable write
  p_en_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel_e == SEL_EN) |=> $stable(en_q));
endmodule

// File: rtl/stat_event_reg.sv
module stat_event_reg
  import stat_pkg::*;
#(
  parameter int unsigned W = STAT_W,
  parameter logic [W-1:0] COND_MASK  = STAT_COND_MASK,
  parameter logic [W-1:0] PULSE_MASK = STAT_PULSE_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cond_in,
  input  logic [W-1:0] pulse_in,
  input  logic [1:0]   reg_sel,
  input  logic         reg_rd,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         summary_o
);
  localparam logic [W-1:0] VALID_MASK = COND_MASK | PULSE_MASK;

  logic [W-1:0] cond_q, rise, evt_q, en_q, set_v;
  logic         evt_clr;

  stat_cond_track #(.W(W), .COND_MASK(COND_MASK)) u_cond (
    .clk(clk), .rst(rst), .cond_in(cond_in), .cond_q(cond_q), .rise(rise)
  );

  assign set_v = rise | (pulse_in & PULSE_MASK);

  stat_event_latch #(.W(W), .VALID_MASK(VALID_MASK)) u_evt (
    .clk(clk), .rst(rst), .set(set_v), .clr(evt_clr), .evt_q(evt_q)
  );

  stat_reg_port #(.W(W), .VALID_MASK(VALID_MASK)) u_port (
    .clk(clk), .rst(rst), .sel(reg_sel), .rd(reg_rd), .wr(reg_wr),
    .wdata(reg_wdata), .cond_q(cond_q), .evt_q(evt_q), .en_q(en_q),
    .rdata(reg_rdata), .evt_clr(evt_clr)
  );

  assign summary_o = |(evt_q & en_q);

  // R9: nothing enabled means no summary
  p_summary_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> !summary_o);
  // R10: a new pulse into an enabled position raises summary next cycle
  p_summary_next_r10: assert property (@(posedge clk) disable iff (rst)
    (((pulse_in & PULSE_MASK & en_q) != '0) && !(reg_wr && reg_sel == 2'd2))
      |=> summary_o);
endmodule

// File: tb/stat_event_reg_tb.sv
module stat_event_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CM = 16'h2D1F;
  localparam logic [15:0] PM = 16'h10E0;
  localparam logic [15:0] VM = 16'h3DFF;

  logic clk = 0, rst = 1;
  logic [15:0] cond_in = 0, pulse_in = 0, reg_wdata = 0, reg_rdata;
  logic [1:0]  reg_sel = 0;
  logic reg_rd = 0, reg_wr = 0, summary_o;

  int checks = 0, failures = 0;
  logic [15:0] m_cond = 0, m_evt = 0, m_en = 0, m_rdata = 0;
  logic [31:0] lfsr = 32'h1BADF00D;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_event_reg dut_i (
    .clk(clk), .rst(rst), .cond_in(cond_in), .pulse_in(pulse_in),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .summary_o(summary_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock edge with model update from the requirements
  task automatic step();
    logic [15:0] setv, n_evt;
    setv  = (cond_in & CM & ~m_cond) | (pulse_in & PM);
    n_evt = ((reg_rd && reg_sel == 2'd1) ? 16'h0 : m_evt) | setv;
    if (reg_rd)
      case (reg_sel)
        2'd0: m_rdata = m_cond;
        2'd1: m_rdata = m_evt;
        2'd2: m_rdata = m_en;
        default: m_rdata = 16'h0;
      endcase
    if (reg_wr && reg_sel == 2'd2) m_en = reg_wdata & VM;
    m_cond = cond_in & CM;
    m_evt  = n_evt;
    @(posedge clk); #1;
    pulse_in = 0; reg_rd = 0; reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [15:0] v);
    reg_sel = s; reg_rd = 1; step(); v = reg_rdata;
  endtask

  task automatic wr_en(input logic [15:0] d);
    reg_sel = 2'd2; reg_wr = 1; reg_wdata = d; step();
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk("R1 summary", {15'h0, summary_o}, 16'h0);
    rd_reg(2'd0, v); chk("R1 cond", v, 16'h0);
    rd_reg(2'd1, v); chk("R1 evt", v, 16'h0);
    rd_reg(2'd2, v); chk("R1 en", v, 16'h0);

    // per-bit sweep: condition rise, pulse, enable
    for (int b = 0; b < 16; b++) begin
      cond_in = 16'h1 << b; step();
      rd_reg(2'd0, v); chk("R2 cond mirror", v, (16'h1 << b) & CM);
      rd_reg(2'd1, v); chk("R3 rise latch", v, (16'h1 << b) & CM);
      rd_reg(2'd1, v); chk("R3 held high no relatch", v, 16'h0);
      cond_in = 0; step();
      rd_reg(2'd1, v); chk("R6 fall no set", v, 16'h0);
      pulse_in = 16'h1 << b; step();
      rd_reg(2'd1, v); chk("R4 pulse", v, (16'h1 << b) & PM);
      wr_en(16'h1 << b);
      rd_reg(2'd2, v); chk("R8 enable rw", v, (16'h1 << b) & VM);
      chk("R9 summary no event", {15'h0, summary_o}, 16'h0);
      pulse_in = 16'h1 << b; cond_in = 16'h1 << b; step();
      chk("R10 summary next cycle", {15'h0, summary_o},
          {15'h0, |((16'h1 << b) & VM)});
      wr_en(16'h0);
      chk("R9 masked summary", {15'h0, summary_o}, 16'h0);
      rd_reg(2'd1, v); chk("R9 masked still latched", v, (16'h1 << b) & VM);
      cond_in = 0; step();
    end

    // R5 unused positions
    wr_en(16'hFFFF);
    rd_reg(2'd2, v); chk("R5 en unused", v, VM);
    cond_in = 16'hFFFF; pulse_in = 16'hFFFF; step();
    rd_reg(2'd0, v); chk("R5 cond unused", v, CM);
    rd_reg(2'd1, v); chk("R5 evt unused", v, VM);
    rd_reg(2'd3, v); chk("R8 sel3 zero", v, 16'h0);
    cond_in = 0; step();

    // R7 set wins at the clearing edge
    pulse_in = 16'h0020; step();
    pulse_in = 16'h1000; reg_sel = 2'd1; reg_rd = 1; step();
    chk("R7 read before clear", reg_rdata, 16'h0020);
    rd_reg(2'd1, v); chk("R7 set wins", v, 16'h1000);
    cond_in = 16'h0002; reg_sel = 2'd1; reg_rd = 1; step();
    chk("R7 read empty", reg_rdata, 16'h0);
    rd_reg(2'd1, v); chk("R7 rise wins", v, 16'h0002);
    step(); chk("R7 rdata holds", reg_rdata, 16'h0002);
    cond_in = 0; step();

    // pseudo-random stream against model
    for (int i = 0; i < 3000; i++) begin
      lfsr = nxt(lfsr);
      cond_in  = lfsr[15:0];
      pulse_in = lfsr[31:16] & {16{lfsr[3]}};
      reg_sel  = lfsr[21:20];
      reg_rd   = lfsr[9];
      reg_wr   = lfsr[17] & lfsr[26];
      reg_wdata = nxt(lfsr)[15:0];
      step();
      chk("R9 random summary", {15'h0, summary_o}, {15'h0, |(m_evt & m_en)});
      chk("R7 random rdata", reg_rdata, m_rdata);
    end

    rst = 1; step(); rst = 0;
    m_cond = 0; m_evt = 0; m_en = 0; m_rdata = 0;
    chk("R1 re-reset summary", {15'h0, summary_o}, 16'h0);
    chk("R1 re-reset rdata", reg_rdata, 16'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule